// File: doc/BRIEF.md
# Timing Reference Selector

This block picks one active timing reference out of a parameterised set of candidate inputs (eight by default) and reports which one is in use. Each candidate has a signal-fail flag, a programmed priority, a received quality-level code and a two-bit external command. A single mode input switches the ranking between priority-only and quality-first. When no candidate can be used, the block stops claiming a valid selection and asks the downstream clock generator to go into holdover. Two separate selection processes, such as one for the system clock and one for the station output clock, are built by instantiating the block twice. Each copy runs the same algorithm and shares no state with the other.

A three-state machine governs the result. `ST_FREERUN` is the state after reset, before any reference has been acquired. `ST_LOCKED` is the state while a reference is in use. `ST_HOLDOVER` is entered when a locked selection loses every candidate. The transitions are:

- "acquire": `ST_FREERUN` to `ST_LOCKED`.
- "lose": `ST_LOCKED` to `ST_HOLDOVER`.
- "recover": `ST_HOLDOVER` to `ST_LOCKED`.
- "reselect": `ST_LOCKED` to `ST_LOCKED` with a new index.
- "wait": staying in `ST_FREERUN` or `ST_HOLDOVER` while nothing is usable.

The ranking is evaluated every cycle from the current inputs, and the result is registered once. The selection is non-revertive. The active reference is kept unless it becomes ineligible or a strictly better candidate appears.

Top module: `trs_selector`

## Requirements
- R1: While reset is high and in the cycle after it, the outputs are sel_valid=0, holdover_req=0 and sel_idx=0. This is `ST_FREERUN`.
- R2: An input is eligible for automatic ranking only if all of these hold: its command is not lockout (code 3), its priority is non-zero, its fail flag is low, and, when qual_mode=1, its quality code is not 15.
- R3: With qual_mode=0, the automatic choice is the eligible input with the lowest priority value. Priority 1 is the most preferred. Ties go to the lower index.
- R4: With qual_mode=1, the automatic choice is the eligible input with the lowest quality code. Ties on quality are decided by the lower priority value, and then by the lower index.
- R5: An active automatic selection is kept while it stays eligible. It changes only if another eligible input has a strictly lower key: (quality, priority) with qual_mode=1, or priority alone with qual_mode=0.
- R6: When the active input fails or otherwise becomes ineligible, the next cycle selects the best remaining eligible input.
- R7: An input under lockout (code 3) is never selected.
- R8: An input under a forced command (code 2) is selected whatever its fail flag, priority or quality code. If several inputs are forced, the lowest index wins. A forced command takes precedence over manual commands and over ranking.
- R9: An input under a manual command (code 1) is selected only if it is eligible under R2. If several manual inputs are eligible, the lowest index wins. A manual command on an ineligible input is ignored.
- R10: When the block is in `ST_LOCKED` and no input is usable, the next cycle shows sel_valid=0 and holdover_req=1 together, and sel_idx keeps the last index.
- R11: From `ST_FREERUN` with no usable input, both sel_valid and holdover_req stay low. Holdover is never requested without a prior lock.
- R12: From `ST_HOLDOVER`, a usable input returns the block to `ST_LOCKED` with sel_valid=1 and holdover_req=0.
- R13: Every output change appears exactly one clock cycle after the input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| qual_mode | input | 1 | 1 = quality-first ranking, 0 = priority-only ranking |
| src_fail | input | N_IN | Per-input signal-fail flag |
| src_prio | input | N_IN*PRIO_W | Per-input priority; 0 means the input is disabled |
| src_ql | input | N_IN*QL_W | Per-input quality code; a lower code is better, and all ones means do-not-use |
| src_cmd | input | N_IN*2 | Per-input command: 0 none, 1 manual, 2 forced, 3 lockout |
| sel_idx | output | $clog2(N_IN) | Index of the active input |
| sel_valid | output | 1 | A reference is selected (`ST_LOCKED`) |
| holdover_req | output | 1 | Lock has been lost and no input is usable (`ST_HOLDOVER`) |

## Verification
The bench targets the following corner cases:

- Equal keys at two inputs. A design that broke ties the wrong way would pick the higher index. A revertive design would leave an equally good active input.
- A do-not-use quality code, which must only matter in quality mode. A design that mixed up the modes would select or skip that input wrongly.
- A forced command on a failed input, and a manual command on a failed input. A design that got this wrong would either refuse the forced one or honour the manual one.
- The FREERUN/HOLDOVER distinction. A design that got this wrong would request holdover straight after reset, or would drop valid without raising the request in the same cycle.

Sweeps over keys and commands compare every cycle against an arithmetic model of the ranking.

// File: rtl/trs_pkg.sv
package trs_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_MANUAL  = 2'd1,
        CMD_FORCED  = 2'd2,
        CMD_LOCKOUT = 2'd3
    } trs_cmd_e;

    typedef enum logic [1:0] {
        ST_FREERUN  = 2'd0,
        ST_LOCKED   = 2'd1,
        ST_HOLDOVER = 2'd2
    } trs_state_e;

    localparam int CMD_W = 2;

endpackage

// File: rtl/trs_qualify.sv
// Per-input qualification: eligibility, command decode and ranking key.
module trs_qualify
    import trs_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int PRIO_W = 3,
    parameter int QL_W   = 4,
    localparam int KEY_W = QL_W + PRIO_W
) (
    input  logic                    qual_mode,
    input  logic [N_IN-1:0]         src_fail,
    input  logic [N_IN*PRIO_W-1:0]  src_prio,
    input  logic [N_IN*QL_W-1:0]    src_ql,
    input  logic [N_IN*CMD_W-1:0]   src_cmd,
    output logic [N_IN-1:0]         elig,
    output logic [N_IN-1:0]         forced,
    output logic [N_IN-1:0]         manual_ok,
    output logic [N_IN*KEY_W-1:0]   key
);

    localparam logic [QL_W-1:0] QL_DNU = {QL_W{1'b1}};

    for (genvar g = 0; g < N_IN; g++) begin : g_in
        logic [PRIO_W-1:0] prio_g;
        logic [QL_W-1:0]   ql_g;
        trs_cmd_e          cmd_g;
        logic              ql_block;

        assign prio_g = src_prio[g*PRIO_W +: PRIO_W];
        assign ql_g   = src_ql[g*QL_W +: QL_W];
        assign cmd_g  = trs_cmd_e'(src_cmd[g*CMD_W +: CMD_W]);

        assign ql_block = qual_mode && (ql_g == QL_DNU);

        assign elig[g] = (cmd_g != CMD_LOCKOUT) && (prio_g != '0)
                       && !src_fail[g] && !ql_block;
        assign forced[g]    = (cmd_g == CMD_FORCED);
        assign manual_ok[g] = (cmd_g == CMD_MANUAL) && elig[g];

        assign key[g*KEY_W +: KEY_W] = qual_mode ? {ql_g, prio_g}
                                                 : {{QL_W{1'b0}}, prio_g};
    end

endmodule

// File: rtl/trs_first.sv
// Lowest-index set bit of a mask.
module trs_first #(
    parameter int N_IN = 8,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0]  mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/trs_rank.sv
// Minimum-key search over eligible inputs; lower index wins equal keys.
module trs_rank #(
    parameter int N_IN  = 8,
    parameter int KEY_W = 7,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0]       elig,
    input  logic [N_IN*KEY_W-1:0] key,
    output logic                  any,
    output logic [IDX_W-1:0]      best_idx,
    output logic [KEY_W-1:0]      best_key
);

    always_comb begin
        any      = 1'b0;
        best_idx = '0;
        best_key = '1;
        for (int i = 0; i < N_IN; i++) begin
            if (elig[i] && (!any || (key[i*KEY_W +: KEY_W] < best_key))) begin
                any      = 1'b1;
                best_idx = IDX_W'(i);
                best_key = key[i*KEY_W +: KEY_W];
            end
        end
    end

endmodule

// File: rtl/trs_selector.sv
// Timing reference selector: command precedence, ranking and lock state machine.
module trs_selector
    import trs_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int PRIO_W = 3,
    parameter int QL_W   = 4,
    localparam int KEY_W = QL_W + PRIO_W,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    qual_mode,
    input  logic [N_IN-1:0]         src_fail,
    input  logic [N_IN*PRIO_W-1:0]  src_prio,
    input  logic [N_IN*QL_W-1:0]    src_ql,
    input  logic [N_IN*2-1:0]       src_cmd,
    output logic [IDX_W-1:0]        sel_idx,
    output logic                    sel_valid,
    output logic                    holdover_req
);

    logic [N_IN-1:0]       elig;
    logic [N_IN-1:0]       forced;
    logic [N_IN-1:0]       manual_ok;
    logic [N_IN*KEY_W-1:0] key;

    logic                  frc_found;
    logic [IDX_W-1:0]      frc_idx;
    logic                  man_found;
    logic [IDX_W-1:0]      man_idx;
    logic                  rnk_any;
    logic [IDX_W-1:0]      rnk_idx;
    logic [KEY_W-1:0]      rnk_key;

    trs_state_e            state_q, state_d;
    logic [IDX_W-1:0]      sel_q, sel_d;

    logic                  have_pick;
    logic [IDX_W-1:0]      pick_idx;
    logic [KEY_W-1:0]      cur_key;
    logic                  keep_cur;

    trs_qualify #(
        .N_IN   (N_IN),
        .PRIO_W (PRIO_W),
        .QL_W   (QL_W)
    ) u_qualify (
        .qual_mode (qual_mode),
        .src_fail  (src_fail),
        .src_prio  (src_prio),
        .src_ql    (src_ql),
        .src_cmd   (src_cmd),
        .elig      (elig),
        .forced    (forced),
        .manual_ok (manual_ok),
        .key       (key)
    );

    trs_first #(.N_IN(N_IN)) u_first_forced (
        .mask  (forced),
        .found (frc_found),
        .idx   (frc_idx)
    );

    trs_first #(.N_IN(N_IN)) u_first_manual (
        .mask  (manual_ok),
        .found (man_found),
        .idx   (man_idx)
    );

    trs_rank #(.N_IN(N_IN), .KEY_W(KEY_W)) u_rank (
        .elig     (elig),
        .key      (key),
        .any      (rnk_any),
        .best_idx (rnk_idx),
        .best_key (rnk_key)
    );

    // Command precedence: forced, then eligible manual, then non-revertive ranking.
    always_comb begin
        cur_key   = key[int'(sel_q)*KEY_W +: KEY_W];
        keep_cur  = (state_q == ST_LOCKED) && elig[sel_q] && !(rnk_key < cur_key);
        have_pick = 1'b1;
        pick_idx  = sel_q;
        if (frc_found) begin
            pick_idx = frc_idx;
        end else if (man_found) begin
            pick_idx = man_idx;
        end else if (rnk_any) begin
            pick_idx = keep_cur ? sel_q : rnk_idx;
        end else begin
            have_pick = 1'b0;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_FREERUN: begin
                if (have_pick) begin
                    state_d = ST_LOCKED;
                    sel_d   = pick_idx;
                end
            end
            ST_LOCKED: begin
                if (have_pick) begin
                    sel_d = pick_idx;
                end else begin
                    state_d = ST_HOLDOVER;
                end
            end
            ST_HOLDOVER: begin
                if (have_pick) begin
                    state_d = ST_LOCKED;
                    sel_d   = pick_idx;
                end
            end
            default: begin
                state_d = ST_FREERUN;
                sel_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREERUN;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // Outputs.
    always_comb begin
        sel_idx      = sel_q;
        sel_valid    = (state_q == ST_LOCKED);
        holdover_req = (state_q == ST_HOLDOVER);
    end

endmodule

// File: rtl/trs_selector_chk.sv
// Property checker for trs_selector, attached by bind.
module trs_selector_chk #(
    parameter int N_IN   = 8,
    parameter int PRIO_W = 3,
    parameter int QL_W   = 4,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  qual_mode,
    input logic [N_IN-1:0]       src_fail,
    input logic [N_IN*QL_W-1:0]  src_ql,
    input logic [N_IN*2-1:0]     src_cmd,
    input logic [IDX_W-1:0]      sel_idx,
    input logic                  sel_valid,
    input logic                  holdover_req
);

    logic [N_IN-1:0]      p_fail;
    logic [N_IN*QL_W-1:0] p_ql;
    logic [N_IN*2-1:0]    p_cmd;
    logic                 p_qm;
    logic [1:0]           cmd_at;
    logic [QL_W-1:0]      ql_at;

    always_ff @(posedge clk) begin
        p_fail <= src_fail;
        p_ql   <= src_ql;
        p_cmd  <= src_cmd;
        p_qm   <= qual_mode;
    end

    assign cmd_at = p_cmd[int'(sel_idx)*2 +: 2];
    assign ql_at  = p_ql[int'(sel_idx)*QL_W +: QL_W];

    // R7: a locked-out input is never the selection.
    assert_no_lockout_sel_R7: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> cmd_at != 2'd3);

    // R2, R8: a failed input is selected only under a forced command.
    assert_fail_needs_force_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && p_fail[sel_idx]) |-> cmd_at == 2'd2);

    // R2: do-not-use quality blocks selection in quality mode unless forced.
    assert_dnu_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && p_qm && cmd_at != 2'd2) |-> ql_at != {QL_W{1'b1}});

    // R10: losing valid raises the holdover request in the same cycle.
    assert_loss_to_holdover_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_valid) |-> holdover_req);

    // R11: holdover only follows a lock or an earlier holdover.
    assert_no_holdover_from_freerun_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(holdover_req) |-> $past(sel_valid));

    // R10, R12: valid and holdover request never coincide.
    assert_exclusive_flags_R12: assert property (@(posedge clk) disable iff (rst)
        !(sel_valid && holdover_req));

endmodule

bind trs_selector trs_selector_chk #(
    .N_IN   (N_IN),
    .PRIO_W (PRIO_W),
    .QL_W   (QL_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .qual_mode    (qual_mode),
    .src_fail     (src_fail),
    .src_ql       (src_ql),
    .src_cmd      (src_cmd),
    .sel_idx      (sel_idx),
    .sel_valid    (sel_valid),
    .holdover_req (holdover_req)
);

// File: tb/trs_selector_bench.sv
module trs_selector_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam int QW = 4;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              qual_mode = 1'b0;
    logic [N-1:0]      src_fail = '0;
    logic [N*PW-1:0]   src_prio = '0;
    logic [N*QW-1:0]   src_ql = '0;
    logic [N*2-1:0]    src_cmd = '0;
    logic [IW-1:0]     sel_idx;
    logic              sel_valid;
    logic              holdover_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model state: 0 freerun, 1 locked, 2 holdover.
    int m_state = 0;
    int m_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trs_selector #(.N_IN(N), .PRIO_W(PW), .QL_W(QW)) u_trs_selector (
        .clk          (clk),
        .rst          (rst),
        .qual_mode    (qual_mode),
        .src_fail     (src_fail),
        .src_prio     (src_prio),
        .src_ql       (src_ql),
        .src_cmd      (src_cmd),
        .sel_idx      (sel_idx),
        .sel_valid    (sel_valid),
        .holdover_req (holdover_req)
    );

    task automatic set_in(input int i, input bit f, input int p, input int q, input int c);
        src_fail[i]          = f;
        src_prio[i*PW +: PW] = PW'(p);
        src_ql[i*QW +: QW]   = QW'(q);
        src_cmd[i*2 +: 2]    = 2'(c);
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) set_in(i, 1'b0, 0, 0, 0);
    endtask

    function automatic bit m_elig(input int i);
        int p = int'(src_prio[i*PW +: PW]);
        int q = int'(src_ql[i*QW +: QW]);
        int c = int'(src_cmd[i*2 +: 2]);
        return (c != 3) && (p != 0) && !src_fail[i] && !(qual_mode && q == 15);
    endfunction

    function automatic int m_key(input int i);
        int p = int'(src_prio[i*PW +: PW]);
        int q = int'(src_ql[i*QW +: QW]);
        return qual_mode ? q * (1 << PW) + p : p;
    endfunction

    // Model of one clock edge, built from R1..R12.
    task automatic model_edge();
        int fi = -1, mi = -1, bi = -1, pick = -1;
        if (rst) begin
            m_state = 0; m_sel = 0; return;
        end
        for (int i = 0; i < N; i++) begin
            if (fi < 0 && src_cmd[i*2 +: 2] == 2'd2) fi = i;
            if (mi < 0 && src_cmd[i*2 +: 2] == 2'd1 && m_elig(i)) mi = i;
            if (m_elig(i) && (bi < 0 || m_key(i) < m_key(bi))) bi = i;
        end
        if (fi >= 0) pick = fi;
        else if (mi >= 0) pick = mi;
        else if (bi >= 0) begin
            if (m_state == 1 && m_elig(m_sel) && !(m_key(bi) < m_key(m_sel))) pick = m_sel;
            else pick = bi;
        end
        if (pick >= 0) begin
            m_state = 1; m_sel = pick;
        end else if (m_state == 1) begin
            m_state = 2;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int e_idx, input bit e_val, input bit e_hold);
        checks++;
        if (sel_idx !== IW'(e_idx) || sel_valid !== e_val || holdover_req !== e_hold) begin
            errors++;
            $display("FAIL %s: idx=%0d valid=%0b hold=%0b expected idx=%0d valid=%0b hold=%0b",
                     tag, sel_idx, sel_valid, holdover_req, e_idx, e_val, e_hold);
        end
    endtask

    task automatic chk_model(input string tag);
        chk(tag, m_sel, m_state == 1, m_state == 2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_all();
        step(); step();
        chk("R1 during reset", 0, 0, 0);
        rst = 1'b0;
        step();
        chk("R1 after reset", 0, 0, 0);

        // R11: nothing usable from freerun.
        set_in(2, 1'b1, 1, 0, 0);
        set_in(5, 1'b0, 0, 0, 0);
        step(); step();
        chk("R11 freerun no candidate", 0, 0, 0);

        // R3 and R13: lowest priority wins, visible one cycle later.
        set_in(3, 1'b0, 4, 0, 0);
        set_in(6, 1'b0, 2, 0, 0);
        @(posedge clk); model_edge();
        @(negedge clk);
        chk("R13 one-cycle latency", 6, 1, 0);
        step();
        chk("R3 lowest priority", 6, 1, 0);

        // R5: an equal key at a lower index does not displace the active input.
        set_in(1, 1'b0, 2, 0, 0);
        step();
        chk("R5 non-revertive on tie", 6, 1, 0);
        // R5: a strictly better key does.
        set_in(4, 1'b0, 1, 0, 0);
        step();
        chk("R5 strictly better", 4, 1, 0);

        // R6: the active input fails.
        src_fail[4] = 1'b1;
        step();
        chk("R6 switch on active alarm", 1, 1, 0);

        // R7: lockout on the active input.
        set_in(1, 1'b0, 2, 0, 3);
        step();
        chk("R7 lockout excludes", 6, 1, 0);

        // R9: a manual command on a failed input is ignored, on a healthy one honoured.
        set_in(0, 1'b1, 5, 0, 1);
        step();
        chk("R9 manual on failed ignored", 6, 1, 0);
        set_in(3, 1'b0, 4, 0, 1);
        step();
        chk("R9 manual honoured", 3, 1, 0);

        // R8: a forced command on a failed, disabled input wins over manual.
        set_in(7, 1'b1, 0, 15, 2);
        step();
        chk("R8 forced overrides", 7, 1, 0);
        set_in(7, 1'b0, 0, 0, 0);
        set_in(3, 1'b0, 4, 0, 0);
        step();
        chk("R5 after forced release", 6, 1, 0);

        // R10: nothing usable from locked.
        clear_all();
        step();
        chk("R10 holdover entry", 6, 0, 1);
        step();
        chk("R10 holdover hold", 6, 0, 1);

        // R12: recovery.
        set_in(2, 1'b0, 7, 0, 0);
        step();
        chk("R12 recover", 2, 1, 0);

        // R4 and R2: quality ranking and do-not-use.
        qual_mode = 1'b1;
        clear_all();
        set_in(0, 1'b0, 1, 15, 0);
        set_in(1, 1'b0, 5, 4, 0);
        set_in(2, 1'b0, 2, 4, 0);
        set_in(3, 1'b0, 1, 11, 0);
        step();
        chk("R4 quality first then priority", 2, 1, 0);
        qual_mode = 1'b0;
        step();
        chk("R2 DNU ignored when quality off", 0, 1, 0);
        qual_mode = 1'b1;
        step();
        chk("R2 DNU excluded when quality on", 2, 1, 0);

        // Sweep over two inputs: every priority pair and a spread of quality codes.
        for (int qm = 0; qm < 2; qm++) begin
            qual_mode = qm[0];
            for (int p0 = 0; p0 < 8; p0++)
                for (int p1 = 0; p1 < 8; p1++)
                    for (int qs = 0; qs < 4; qs++) begin
                        clear_all();
                        set_in(2, 1'b0, p0, (qs == 3) ? 15 : qs, 0);
                        set_in(5, 1'b0, p1, (qs == 1) ? 15 : 2 - qs % 2, 0);
                        step();
                        chk_model(qm ? "R4 sweep" : "R3 sweep");
                    end
        end

        // Incremental random walk: one input changes per cycle, so hold-on-tie matters.
        for (int n = 0; n < 6000; n++) begin
            int i = $urandom % N;
            int r = $urandom % 16;
            if (n % 1000 == 0) qual_mode = ~qual_mode;
            set_in(i, ($urandom % 4) == 0, $urandom % 8, $urandom % 16,
                   (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 3 : 0);
            if ((n % 97) == 0) clear_all();
            step();
            chk_model("R5 R6 R8 R9 R10 R12 random walk");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule